// File: doc/BRIEF.md
# Bank Auto-Precharge and Activate Timing Tracker

This block follows the timing state of a single DRAM bank and decides two things. It decides when the bank may carry out the internal precharge that a read or write with auto-precharge has requested. It also decides when a new activate to the bank becomes legal. A controller drives one command strobe per cycle, together with an auto-precharge flag, the burst configuration, the current write latency and a flag for the slow DLL-off mode. In return it receives an internal-precharge pulse and flags that show whether each command class may be issued now.

All timing arrives as picosecond parameters and is turned into clock counts at elaboration. Three saturating down-counters hold the counts: one for the active row, one for write recovery and one for precharge-to-activate. An auto-precharge that is requested early is held until both the row-active time and the write recovery have run out. Commands issued against the wrong row state are refused and set a sticky error flag.

Top module: `bank_pre_tracker`

## Requirements
- R1: Each timing parameter becomes a clock count as ceil(ps / CLK_PS). With the defaults (2500 ps clock) the counts are row-precharge 6, row-active 15 and write recovery 6. In DLL-off mode the write-recovery count is max(4, ceil(15000 / DLL_CLK_PS)), which is 4 for the default 8000 ps.
- R2: Suppose a precharge (explicit or internal) takes effect at edge T0. Then `act_ok` stays low before edge T0+6, and an activate sampled at edge T0+6 is accepted and opens the row.
- R3: An internal precharge never takes effect earlier than 15 edges after the activate edge. A read with auto-precharge issued one cycle after the activate therefore closes the row at activate edge + 15.
- R4: With an 8-beat burst (`bc4`=0, either value of `bl_otf`), write recovery starts WL+4 edges after the write edge. An auto-precharge write sampled at edge W closes the row at W+WL+4+6 at the earliest.
- R5: With a 4-beat chop selected per command (`bl_otf`=1, `bc4`=1), write recovery also starts WL+4 edges after the write.
- R6: With a 4-beat chop fixed by configuration (`bl_otf`=0, `bc4`=1), write recovery starts WL+2 edges after the write.
- R7: A write sampled with `dll_off`=1 uses the DLL-off recovery count (4) in place of the normal count (6).
- R8: `ipre_fire` is high for exactly one cycle. That cycle is the first one in which an auto-precharge is pending and the row-active and write-recovery counts have both expired. The row closes at the following edge.
- R9: `proto_err` rises, and stays high until reset, when any of these is sampled: a read or write while `rw_ok` is low, or an activate while `act_ok` is low. A refused command changes no other state.
- R10: `rw_ok` is high while the row is open and no auto-precharge is pending. `pre_ok` additionally needs both counts expired. An explicit precharge sampled while `pre_ok` is low is ignored: the row stays open and no error is raised.
- R11: Reset is synchronous and active high. After reset the row is closed, every count is expired and nothing is pending, so `act_ok`=1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_pre | input | 1 | Explicit precharge strobe |
| cmd_ap | input | 1 | Auto-precharge flag for read/write |
| bl_otf | input | 1 | 1: burst length chosen per command; 0: fixed by configuration |
| bc4 | input | 1 | 1: 4-beat chop; 0: 8-beat burst |
| wr_lat | input | WL_W | Write latency in clocks |
| dll_off | input | 1 | DLL-off mode, selects the long-clock recovery count |
| ipre_fire | output | 1 | Internal precharge pulse, takes effect at the next edge |
| act_ok | output | 1 | Activate is legal at the next edge |
| rw_ok | output | 1 | Read or write is legal at the next edge |
| pre_ok | output | 1 | Explicit precharge is legal at the next edge |
| row_open | output | 1 | A row is open in the bank |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Several properties are checked on every cycle. The internal-precharge pulse lasts one cycle and closes the row. It never comes before the row-active window has run, counted independently of the design. `act_ok` never rises earlier than the row-precharge count after a close. An accepted activate opens the row, and the error flag stays high once set. The write-recovery start points are a different matter. Whether the offset is four or two beats past the write latency, which recovery count DLL-off selects, and what a refused command leaves behind can only be shown by the bench's directed scenarios and its edge-indexed reference model.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

   // counter slots inside the tracker
   localparam int SLOT_RAS = 0;
   localparam int SLOT_WR  = 1;
   localparam int SLOT_RP  = 2;
   localparam int N_SLOTS  = 3;

   // write recovery start offsets past write latency, in clocks
   localparam int WR_OFS_LONG  = 4;
   localparam int WR_OFS_SHORT = 2;

   // floor for the recovery count in DLL-off mode
   localparam int WR_DLLOFF_FLOOR = 4;

   typedef enum logic [1:0] {
      BURST_8      = 2'd0,
      CHOP4_FIXED  = 2'd1,
      CHOP4_OTF    = 2'd2
   } burst_kind_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic burst_kind_e classify_burst(input logic otf, input logic chop);
      if (!chop)      return BURST_8;
      else if (otf)   return CHOP4_OTF;
      else            return CHOP4_FIXED;
   endfunction

endpackage

// File: rtl/bpt_sat_down.sv
module bpt_sat_down #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign count   = cnt_q;
   assign expired = (cnt_q == '0);
endmodule

// File: rtl/bpt_wr_load.sv
module bpt_wr_load
   import bpt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int WL_W        = 4,
   parameter int N_WR        = 6,
   parameter int N_WR_DLLOFF = 4
) (
   input  logic [WL_W-1:0]  wr_lat,
   input  logic             bl_otf,
   input  logic             bc4,
   input  logic             dll_off,
   output logic [CNT_W-1:0] load_val
);
   burst_kind_e  kind;
   logic [CNT_W-1:0] ofs;
   logic [CNT_W-1:0] rec;

   always_comb begin
      kind = classify_burst(bl_otf, bc4);
      case (kind)
         CHOP4_FIXED: ofs = CNT_W'(WR_OFS_SHORT);
         default:     ofs = CNT_W'(WR_OFS_LONG);
      endcase
   end

   generate
      if (N_WR == N_WR_DLLOFF) begin : g_rec_single
         assign rec = CNT_W'(N_WR);
      end else begin : g_rec_mux
         assign rec = dll_off ? CNT_W'(N_WR_DLLOFF) : CNT_W'(N_WR);
      end
   endgenerate

   // counter expires on the edge before the first legal closing edge
   assign load_val = CNT_W'(wr_lat) + ofs + rec - CNT_W'(1);
endmodule

// File: rtl/bank_pre_tracker.sv
module bank_pre_tracker
   import bpt_pkg::*;
#(
   parameter int CLK_PS        = 2500,
   parameter int DLL_CLK_PS    = 8000,
   parameter int T_RP_PS       = 15000,
   parameter int T_RAS_PS      = 37500,
   parameter int T_WR_PS       = 15000,
   parameter int CNT_W         = 8,
   parameter int WL_W          = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cmd_act,
   input  logic            cmd_rd,
   input  logic            cmd_wr,
   input  logic            cmd_pre,
   input  logic            cmd_ap,
   input  logic            bl_otf,
   input  logic            bc4,
   input  logic [WL_W-1:0] wr_lat,
   input  logic            dll_off,
   output logic            ipre_fire,
   output logic            act_ok,
   output logic            rw_ok,
   output logic            pre_ok,
   output logic            row_open,
   output logic            proto_err
);
   localparam int N_RP        = ceil_div(T_RP_PS, CLK_PS);
   localparam int N_RAS       = ceil_div(T_RAS_PS, CLK_PS);
   localparam int N_WR        = ceil_div(T_WR_PS, CLK_PS);
   localparam int N_WR_DLLOFF = max_int(WR_DLLOFF_FLOOR, ceil_div(15000, DLL_CLK_PS));
   localparam int MAX_WR_LOAD = (2**WL_W - 1) + WR_OFS_LONG + max_int(N_WR, N_WR_DLLOFF);

   // elaboration-time parameter checks
   generate
      if (CLK_PS <= 0 || DLL_CLK_PS <= 0) begin : g_bad_clk
         $error("bank_pre_tracker: clock periods must be positive");
      end
      if (N_RP < 1 || N_RAS < 1 || N_WR < 1) begin : g_bad_cnt
         $error("bank_pre_tracker: timing counts must be at least one clock");
      end
      if (MAX_WR_LOAD >= 2**CNT_W || N_RAS >= 2**CNT_W || N_RP >= 2**CNT_W) begin : g_bad_w
         $error("bank_pre_tracker: CNT_W too narrow for the timing counts");
      end
   endgenerate

   logic [CNT_W-1:0] ld_val  [N_SLOTS];
   logic [CNT_W-1:0] cnt_now [N_SLOTS];
   logic             ld      [N_SLOTS];
   logic             done    [N_SLOTS];

   logic [CNT_W-1:0] wr_ld_val;
   logic open_q, pend_q, err_q;
   logic fire, act_acc, rd_acc, wr_acc, pre_acc, refused;

   bpt_wr_load #(
      .CNT_W      (CNT_W),
      .WL_W       (WL_W),
      .N_WR       (N_WR),
      .N_WR_DLLOFF(N_WR_DLLOFF)
   ) u_wr_load (
      .wr_lat  (wr_lat),
      .bl_otf  (bl_otf),
      .bc4     (bc4),
      .dll_off (dll_off),
      .load_val(wr_ld_val)
   );

   // legality of each command class at the coming edge
   always_comb begin
      fire    = pend_q & done[SLOT_RAS] & done[SLOT_WR];
      act_ok  = ~open_q & done[SLOT_RP];
      rw_ok   = open_q & ~pend_q;
      pre_ok  = rw_ok & done[SLOT_RAS] & done[SLOT_WR];
      act_acc = cmd_act & act_ok;
      rd_acc  = cmd_rd & rw_ok;
      wr_acc  = cmd_wr & rw_ok;
      pre_acc = cmd_pre & pre_ok;
      refused = (cmd_act & ~act_ok) | ((cmd_rd | cmd_wr) & ~rw_ok);
   end

   always_comb begin
      ld[SLOT_RAS]     = act_acc;
      ld_val[SLOT_RAS] = CNT_W'(N_RAS - 1);
      ld[SLOT_WR]      = wr_acc;
      ld_val[SLOT_WR]  = wr_ld_val;
      ld[SLOT_RP]      = pre_acc | fire;
      ld_val[SLOT_RP]  = CNT_W'(N_RP - 1);
   end

   generate
      for (genvar s = 0; s < N_SLOTS; s++) begin : g_cnt
         bpt_sat_down #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .load    (ld[s]),
            .load_val(ld_val[s]),
            .count   (cnt_now[s]),
            .expired (done[s])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= 1'b0;
         pend_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (act_acc)
            open_q <= 1'b1;
         else if (pre_acc | fire)
            open_q <= 1'b0;

         if (fire)
            pend_q <= 1'b0;
         else if ((rd_acc | wr_acc) & cmd_ap)
            pend_q <= 1'b1;

         if (refused)
            err_q <= 1'b1;
      end
   end

   assign ipre_fire = fire;
   assign row_open  = open_q;
   assign proto_err = err_q;
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
   parameter int N_RAS = 15,
   parameter int N_RP  = 6
) (
   input logic clk,
   input logic rst,
   input logic cmd_act,
   input logic cmd_pre,
   input logic ipre_fire,
   input logic act_ok,
   input logic pre_ok,
   input logic row_open,
   input logic proto_err
);
   localparam int SAT = 1 << 15;

   int unsigned since_act;
   int unsigned since_close;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_act   <= SAT;
         since_close <= SAT;
      end else begin
         if (cmd_act && act_ok)          since_act <= 1;
         else if (since_act < SAT)       since_act <= since_act + 1;
         if (ipre_fire || (cmd_pre && pre_ok)) since_close <= 1;
         else if (since_close < SAT)     since_close <= since_close + 1;
      end
   end

   assert_fire_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      ipre_fire |=> !ipre_fire);

   assert_fire_closes_row_R8: assert property (@(posedge clk) disable iff (rst)
      ipre_fire |=> !row_open);

   assert_ras_window_R3: assert property (@(posedge clk) disable iff (rst)
      ipre_fire |-> (since_act >= N_RAS));

   assert_rp_window_R2: assert property (@(posedge clk) disable iff (rst)
      act_ok |-> (since_close >= N_RP));

   assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
      (cmd_act && act_ok) |=> row_open);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err);
endmodule

bind bank_pre_tracker bpt_checker #(
   .N_RAS(N_RAS),
   .N_RP (N_RP)
) u_bpt_chk (
   .clk      (clk),
   .rst      (rst),
   .cmd_act  (cmd_act),
   .cmd_pre  (cmd_pre),
   .ipre_fire(ipre_fire),
   .act_ok   (act_ok),
   .pre_ok   (pre_ok),
   .row_open (row_open),
   .proto_err(proto_err)
);

// File: tb/bank_pre_tracker_tb_top.sv
module bank_pre_tracker_tb_top;
   localparam int CLK_NS   = 10;
   localparam int E_RP     = 6;
   localparam int E_RAS    = 15;
   localparam int E_WR     = 6;
   localparam int E_WR_DLL = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, cmd_ap = 0;
   logic bl_otf = 0, bc4 = 0, dll_off = 0;
   logic [3:0] wr_lat = 4'd5;
   logic ipre_fire, act_ok, rw_ok, pre_ok, row_open, proto_err;

   int tests = 0;
   int fails = 0;
   bit done_flag = 0;

   always #(CLK_NS/2) clk = ~clk;

   bank_pre_tracker dut_i (
      .clk(clk), .rst(rst),
      .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
      .cmd_ap(cmd_ap), .bl_otf(bl_otf), .bc4(bc4), .wr_lat(wr_lat), .dll_off(dll_off),
      .ipre_fire(ipre_fire), .act_ok(act_ok), .rw_ok(rw_ok), .pre_ok(pre_ok),
      .row_open(row_open), .proto_err(proto_err)
   );

   // reference model: edge-indexed "ready at edge" bookkeeping
   longint e = 0;
   longint ras_ready = 0, wr_ready = 0, rp_ready = 0;
   bit m_open = 0, m_pend = 0, m_err = 0;
   bit m_fire, m_act, m_rw, m_pre;

   always @(posedge clk) begin
      e = e + 1;
      if (rst) begin
         m_open = 0; m_pend = 0; m_err = 0;
         ras_ready = 0; wr_ready = 0; rp_ready = 0;
      end else begin
         m_fire = m_pend && (e >= ras_ready) && (e >= wr_ready);
         m_act  = !m_open && (e >= rp_ready);
         m_rw   = m_open && !m_pend;
         m_pre  = m_rw && (e >= ras_ready) && (e >= wr_ready);
         if (cmd_act) begin
            if (m_act) begin m_open = 1; ras_ready = e + E_RAS; end
            else m_err = 1;
         end
         if (cmd_wr || cmd_rd) begin
            if (m_rw) begin
               if (cmd_wr)
                  wr_ready = e + wr_lat + ((bc4 && !bl_otf) ? 2 : 4) + (dll_off ? E_WR_DLL : E_WR);
               if (cmd_ap) m_pend = 1;
            end else m_err = 1;
         end
         if (cmd_pre && m_pre) begin m_open = 0; rp_ready = e + E_RP; end
         if (m_fire) begin m_open = 0; m_pend = 0; rp_ready = e + E_RP; end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R2 R8 R9 R10)
   always @(negedge clk) begin
      if (!rst && !done_flag) begin
         longint n;
         n = e + 1;
         chk("R8", "ipre_fire", ipre_fire, m_pend && n >= ras_ready && n >= wr_ready);
         chk("R2", "act_ok", act_ok, !m_open && n >= rp_ready);
         chk("R10", "rw_ok", rw_ok, m_open && !m_pend);
         chk("R10", "pre_ok", pre_ok, m_open && !m_pend && n >= ras_ready && n >= wr_ready);
         chk("R2", "row_open", row_open, m_open);
         chk("R9", "proto_err", proto_err, m_err);
      end
   end

   task automatic issue(input bit a, input bit r, input bit w, input bit p, input bit ap,
                        input bit otf, input bit chop, input bit dll, input int wl);
      cmd_act = a; cmd_rd = r; cmd_wr = w; cmd_pre = p; cmd_ap = ap;
      bl_otf = otf; bc4 = chop; dll_off = dll; wr_lat = 4'(wl);
      @(negedge clk);
      cmd_act = 0; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; cmd_ap = 0;
   endtask

   task automatic wait_fire(output int n);
      n = 0;
      while (!ipre_fire && n < 100) begin @(negedge clk); n++; end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic write_ap_case(input string req, input bit otf, input bit chop,
                                input bit dll, input int expn);
      int n;
      issue(1,0,0,0,0, 0,0,0,5);
      idle(20);
      issue(0,0,1,0,1, otf,chop,dll,5);
      wait_fire(n);
      chk(req, "write-to-fire cycles", n, expn);
      idle(10);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst = 0;
      // R11 reset state
      chk("R11", "act_ok after reset", act_ok, 1);
      chk("R11", "row_open after reset", row_open, 0);
      chk("R11", "ipre_fire after reset", ipre_fire, 0);
      chk("R11", "rw_ok/pre_ok after reset", {30'd0, rw_ok, pre_ok}, 0);
      chk("R11", "proto_err after reset", proto_err, 0);

      // R10: early explicit precharge is ignored without error
      issue(1,0,0,0,0, 0,0,0,5);
      chk("R2", "row opened by activate", row_open, 1);
      issue(0,0,0,1,0, 0,0,0,5);
      chk("R10", "row still open after early precharge", row_open, 1);
      chk("R10", "no error from early precharge", proto_err, 0);
      idle(20);
      chk("R10", "pre_ok once row-active window ran", pre_ok, 1);
      issue(0,0,0,1,0, 0,0,0,5);
      chk("R10", "row closed by legal precharge", row_open, 0);
      // R1 R2: activate legal 6 edges after the precharge edge
      n = 0;
      while (!act_ok && n < 50) begin @(negedge clk); n++; end
      chk("R1", "precharge-to-act_ok cycles", n, E_RP - 1);

      // R3: read with auto-precharge right after activate
      issue(1,0,0,0,0, 0,0,0,5);
      issue(0,1,0,0,1, 0,0,0,5);
      wait_fire(n);
      chk("R3", "read-to-fire cycles", n, E_RAS - 2);
      @(negedge clk);
      chk("R8", "fire is one cycle", ipre_fire, 0);
      chk("R8", "row closed after fire", row_open, 0);
      n = 1;
      while (!act_ok && n < 50) begin @(negedge clk); n++; end
      chk("R2", "fire-to-act_ok cycles", n, E_RP);
      idle(5);

      write_ap_case("R4", 0, 0, 0, 5 + 4 + E_WR - 1);
      write_ap_case("R4", 1, 0, 0, 5 + 4 + E_WR - 1);
      write_ap_case("R5", 1, 1, 0, 5 + 4 + E_WR - 1);
      write_ap_case("R6", 0, 1, 0, 5 + 2 + E_WR - 1);
      write_ap_case("R7", 0, 0, 1, 5 + 4 + E_WR_DLL - 1);

      // R9: refused read with row closed, error sticky, no state change
      issue(0,1,0,0,1, 0,0,0,5);
      chk("R9", "error after read on closed row", proto_err, 1);
      chk("R9", "refused read opened nothing", row_open, 0);
      idle(20);
      chk("R9", "refused read left no pending precharge", ipre_fire, 0);
      chk("R9", "error stays set", proto_err, 1);

      // random traffic checked against the model each cycle
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom % 10;
         if (r < 4)
            issue(r == 0, r == 1, r == 2, r == 3, $urandom % 2,
                  $urandom % 2, $urandom % 2, $urandom % 2, 3 + $urandom % 6);
         else
            @(negedge clk);
      end

      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule